// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block takes a request made of buffer segments and turns it into the descriptor table that a bus-master disk DMA engine walks. Each segment has a start address and a byte length. Software or an upstream engine opens a request with a `start` pulse. It then streams the segments over a valid/ready interface and marks the final one with `seg_last`. The block writes the table into a local descriptor memory, one 32-bit word per cycle. Each entry takes two words. The even word holds the physical base. The odd word holds the byte count in its low half, and bit 31 of that word marks the final entry.

A segment that begins exactly where the pending region ends is folded into that region. This merge happens before any splitting. A region is cut wherever it would cross a 64 KB address boundary. A chunk of exactly 64 KB is written with a count field of zero. The block reports failure in three cases, so that the request can fall back to programmed I/O: the table would exceed its capacity, the request yields no entries, or a segment has an odd address or length. After a failure, the rest of the request's segments are accepted and dropped.

Back-pressure rules: `seg_ready` is high only while the block can take a segment. It stays low while the block is idle, while it is emitting the chunks of a region, and during the done cycle. A segment is taken on a cycle where `seg_valid` and `seg_ready` are both high. The upstream side must hold the segment fields stable until that cycle.

Top module: `sg_desc_builder`

## Requirements
- R1: While reset is held and after it is released, `seg_ready`, `desc_we`, `done` and `fail` are low and `entry_count` is zero.
- R2: Entry k is written at word address 2k with the base address and at word address 2k+1 with the byte count in bits 15:0; bits 30:16 of a count word are zero.
- R3: No entry crosses a 64 KB boundary: each chunk is the smaller of the bytes left in the region and 0x10000 minus the low 16 bits of its base address.
- R4: A chunk of exactly 0x10000 bytes is written with a count field of 0x0000.
- R5: A segment whose address equals the pending region's base plus its size is merged into that region before splitting, so a merged region can span two former segments in one entry. A segment that only touches the region from below is not merged.
- R6: On success, the count word of the last entry is written a second time with bit 31 set. A request with N entries makes exactly 2N+1 writes, and only that final write has bit 31 set.
- R7: If a chunk must be emitted while `entry_count` equals CAPACITY, the block raises `fail`, writes no end marker, and leaves `entry_count` at CAPACITY.
- R8: A request that yields no entries, for example a single zero-length segment, ends with `fail` high and `entry_count` zero.
- R9: A segment with bit 0 of its address or bit 0 of its length set raises `fail`.
- R10: After a failure, the block keeps `seg_ready` high and drops segments until one with `seg_last` is taken. It then pulses `done`.
- R11: `seg_ready` is low when idle, low while a region's chunks are being written, and low in the cycle `done` is high. `done` is a single-cycle pulse.
- R12: A `start` pulse taken while idle clears `entry_count` and `fail` before the first segment is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new request when idle |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Block can take a segment |
| seg_addr | input | 32 | Segment physical start address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the request |
| desc_we | output | 1 | Descriptor memory write strobe |
| desc_waddr | output | $clog2(CAPACITY)+1 | Descriptor memory word address |
| desc_wdata | output | 32 | Descriptor memory write data |
| done | output | 1 | One-cycle pulse when the request ends |
| entry_count | output | $clog2(CAPACITY+1) | Entries written for the current request |
| fail | output | 1 | Request could not be turned into a table |

## Verification
The build is driven with several kinds of request. Single short segments check the word layout. Adjacent pairs must collapse into one entry. Gapped pairs and pairs that only touch from below must not merge. A segment straddling a 64 KB line must split in two. Aligned 64 KB and 128 KB segments expose the zero count encoding. A merge that lands across a boundary shows that merging comes before splitting. Requests that fill the table exactly or overrun it by one chunk separate the capacity limit from an off-by-one. Zero-length and odd requests, with and without segments after the fault, check the failure paths and the discarding of the tail.

// File: rtl/sg_desc_pkg.sv
package sg_desc_pkg;
  localparam int unsigned BOUNDARY_BITS = 16;
  localparam int unsigned CHUNK_W = BOUNDARY_BITS + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAKE,
    ST_BASE,
    ST_COUNT,
    ST_MARK,
    ST_DRAIN,
    ST_DONE
  } build_state_e;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_BASE,
    WR_COUNT,
    WR_MARK
  } wr_kind_e;
endpackage

// File: rtl/sg_chunk_calc.sv
module sg_chunk_calc
  import sg_desc_pkg::*;
#(
  parameter int unsigned SZ_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         base,
  input  logic [SZ_W-1:0]     remain,
  output logic [CHUNK_W-1:0]  chunk
);
  logic [CHUNK_W-1:0] to_edge;
  logic [SZ_W-1:0]    edge_w;
  logic [CHUNK_W:0]   reach;

  // bytes left before the next boundary: 1 .. 0x10000
  assign to_edge = CHUNK_W'(1 << BOUNDARY_BITS) - CHUNK_W'(base[BOUNDARY_BITS-1:0]);
  assign edge_w  = SZ_W'(to_edge);
  assign chunk   = (remain < edge_w) ? remain[CHUNK_W-1:0] : to_edge;
  assign reach   = (CHUNK_W+1)'(base[BOUNDARY_BITS-1:0]) + (CHUNK_W+1)'(chunk);

  assert_no_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0) |-> (chunk != '0) && (reach <= (CHUNK_W+1)'(1 << BOUNDARY_BITS)));

  assert_chunk_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0) |-> (SZ_W'(chunk) <= remain));
endmodule

// File: rtl/sg_desc_writer.sv
module sg_desc_writer
  import sg_desc_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  wr_kind_e               kind,
  input  logic [IDX_W-1:0]       idx,
  input  logic [31:0]            base,
  input  logic [BOUNDARY_BITS-1:0] count_lo,
  output logic                   we,
  output logic [IDX_W:0]         waddr,
  output logic [31:0]            wdata
);
  always_comb begin
    we    = 1'b0;
    waddr = '0;
    wdata = '0;
    case (kind)
      WR_BASE: begin
        we    = 1'b1;
        waddr = {idx, 1'b0};
        wdata = base;
      end
      WR_COUNT: begin
        we    = 1'b1;
        waddr = {idx, 1'b1};
        wdata = {16'h0000, count_lo};
      end
      WR_MARK: begin
        we    = 1'b1;
        waddr = {idx, 1'b1};
        wdata = {1'b1, 15'h0000, count_lo};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sg_desc_builder.sv
module sg_desc_builder
  import sg_desc_pkg::*;
#(
  parameter int unsigned CAPACITY = 256,
  parameter int unsigned LEN_W    = 20,
  parameter int unsigned SZ_W     = 24,
  localparam int unsigned IDX_W   = $clog2(CAPACITY),
  localparam int unsigned CNT_W   = $clog2(CAPACITY + 1),
  localparam int unsigned AW      = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [31:0]       seg_addr,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_last,
  output logic              desc_we,
  output logic [AW-1:0]     desc_waddr,
  output logic [31:0]       desc_wdata,
  output logic              done,
  output logic [CNT_W-1:0]  entry_count,
  output logic              fail
);
  build_state_e state;
  logic [31:0]            cur_base;
  logic [SZ_W-1:0]        cur_rem;
  logic [31:0]            pend_base;
  logic [SZ_W-1:0]        pend_size;
  logic                   pend_valid;
  logic                   last_seen;
  logic [CNT_W-1:0]       cnt;
  logic                   fail_q;
  logic [BOUNDARY_BITS-1:0] final_lo;

  logic [CHUNK_W-1:0]     chunk;
  logic                   misalign;
  logic                   contig;
  logic                   region_empty;
  logic                   table_full;
  wr_kind_e               wr_kind;
  logic [IDX_W-1:0]       wr_idx;
  logic [BOUNDARY_BITS-1:0] wr_lo;

  sg_chunk_calc #(.SZ_W(SZ_W)) u_chunk (
    .clk    (clk),
    .rst_n  (rst_n),
    .base   (cur_base),
    .remain (cur_rem),
    .chunk  (chunk)
  );

  assign misalign     = seg_addr[0] | seg_len[0];
  assign contig       = pend_valid && (seg_addr == (pend_base + 32'(pend_size)));
  assign region_empty = (cur_rem == '0);
  assign table_full   = (cnt == CNT_W'(CAPACITY));

  always_comb begin
    wr_kind = WR_NONE;
    wr_idx  = IDX_W'(cnt);
    wr_lo   = chunk[BOUNDARY_BITS-1:0];
    case (state)
      ST_BASE:  if (!region_empty && !table_full) wr_kind = WR_BASE;
      ST_COUNT: wr_kind = WR_COUNT;
      ST_MARK: begin
        wr_kind = WR_MARK;
        wr_idx  = IDX_W'(cnt - CNT_W'(1));
        wr_lo   = final_lo;
      end
      default: ;
    endcase
  end

  sg_desc_writer #(.IDX_W(IDX_W)) u_writer (
    .kind     (wr_kind),
    .idx      (wr_idx),
    .base     (cur_base),
    .count_lo (wr_lo),
    .we       (desc_we),
    .waddr    (desc_waddr),
    .wdata    (desc_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_base   <= '0;
      cur_rem    <= '0;
      pend_base  <= '0;
      pend_size  <= '0;
      pend_valid <= 1'b0;
      last_seen  <= 1'b0;
      cnt        <= '0;
      fail_q     <= 1'b0;
      final_lo   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cnt        <= '0;
            fail_q     <= 1'b0;
            pend_valid <= 1'b0;
            cur_rem    <= '0;
            last_seen  <= 1'b0;
            state      <= ST_TAKE;
          end
        end
        ST_TAKE: begin
          if (seg_valid) begin
            last_seen <= seg_last;
            if (misalign) begin
              fail_q <= 1'b1;
              state  <= seg_last ? ST_DONE : ST_DRAIN;
            end else if (contig) begin
              pend_size <= pend_size + SZ_W'(seg_len);
              if (seg_last) state <= ST_BASE;
            end else begin
              if (pend_valid) begin
                cur_base <= pend_base;
                cur_rem  <= pend_size;
              end
              pend_base  <= seg_addr;
              pend_size  <= SZ_W'(seg_len);
              pend_valid <= 1'b1;
              state      <= ST_BASE;
            end
          end
        end
        ST_BASE: begin
          if (region_empty) begin
            if (!last_seen) begin
              state <= ST_TAKE;
            end else if (pend_valid) begin
              cur_base   <= pend_base;
              cur_rem    <= pend_size;
              pend_valid <= 1'b0;
            end else if (cnt == '0) begin
              fail_q <= 1'b1;
              state  <= ST_DONE;
            end else begin
              state <= ST_MARK;
            end
          end else if (table_full) begin
            fail_q <= 1'b1;
            state  <= last_seen ? ST_DONE : ST_DRAIN;
          end else begin
            state <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          cur_base <= cur_base + 32'(chunk);
          cur_rem  <= cur_rem - SZ_W'(chunk);
          final_lo <= chunk[BOUNDARY_BITS-1:0];
          cnt      <= cnt + CNT_W'(1);
          state    <= ST_BASE;
        end
        ST_MARK:  state <= ST_DONE;
        ST_DRAIN: if (seg_valid && seg_last) state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign seg_ready   = (state == ST_TAKE) || (state == ST_DRAIN);
  assign done        = (state == ST_DONE);
  assign entry_count = cnt;
  assign fail        = fail_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_count <= CNT_W'(CAPACITY));

  assert_quiet_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |-> !seg_ready);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!seg_ready && !desc_we));

  assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_count != $past(entry_count)) |->
      ((entry_count == $past(entry_count) + CNT_W'(1)) || (entry_count == '0)));

  assert_mark_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && desc_wdata[31]) |-> (desc_waddr == AW'({IDX_W'(entry_count - CNT_W'(1)), 1'b1})));
endmodule

// File: tb/sg_desc_builder_test.sv
`timescale 1ns/1ps
module sg_desc_builder_test;
  localparam int CAP   = 8;
  localparam int LEN_W = 20;
  localparam int SZ_W  = 24;
  localparam int AW    = $clog2(CAP) + 1;
  localparam int CW    = $clog2(CAP + 1);
  localparam int NV    = 16;

  typedef struct packed {
    logic [1:0]       nseg;
    logic [31:0]      a0;
    logic [LEN_W-1:0] l0;
    logic [31:0]      a1;
    logic [LEN_W-1:0] l1;
    logic [31:0]      a2;
    logic [LEN_W-1:0] l2;
    logic [3:0]       exp_cnt;
    logic             exp_fail;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd1, 32'h0000_1000, 20'h00200, 32'h0, 20'h0, 32'h0, 20'h0, 4'd1, 1'b0},
    '{2'd2, 32'h0000_2000, 20'h00100, 32'h0000_2100, 20'h00300, 32'h0, 20'h0, 4'd1, 1'b0},
    '{2'd2, 32'h0000_3000, 20'h00100, 32'h0000_5000, 20'h00080, 32'h0, 20'h0, 4'd2, 1'b0},
    '{2'd1, 32'h0001_FF00, 20'h00200, 32'h0, 20'h0, 32'h0, 20'h0, 4'd2, 1'b0},
    '{2'd1, 32'h0004_0000, 20'h10000, 32'h0, 20'h0, 32'h0, 20'h0, 4'd1, 1'b0},
    '{2'd1, 32'h0005_0000, 20'h20000, 32'h0, 20'h0, 32'h0, 20'h0, 4'd2, 1'b0},
    '{2'd2, 32'h0000_FFF0, 20'h00010, 32'h0001_0000, 20'h00020, 32'h0, 20'h0, 4'd2, 1'b0},
    '{2'd3, 32'h0000_6000, 20'h00040, 32'h0000_6040, 20'h00040, 32'h0000_9000, 20'h00010, 4'd2, 1'b0},
    '{2'd1, 32'h0000_0000, 20'h80000, 32'h0, 20'h0, 32'h0, 20'h0, 4'd8, 1'b0},
    '{2'd1, 32'h0000_0000, 20'h90000, 32'h0, 20'h0, 32'h0, 20'h0, 4'd8, 1'b1},
    '{2'd1, 32'h0000_0100, 20'h00000, 32'h0, 20'h0, 32'h0, 20'h0, 4'd0, 1'b1},
    '{2'd1, 32'h0000_0101, 20'h00010, 32'h0, 20'h0, 32'h0, 20'h0, 4'd0, 1'b1},
    '{2'd1, 32'h0000_0100, 20'h00011, 32'h0, 20'h0, 32'h0, 20'h0, 4'd0, 1'b1},
    '{2'd2, 32'h0000_7000, 20'h00100, 32'h0000_6F00, 20'h00100, 32'h0, 20'h0, 4'd2, 1'b0},
    '{2'd3, 32'h0000_0000, 20'h90000, 32'h000A_0000, 20'h00010, 32'h000B_0000, 20'h00010, 4'd8, 1'b1},
    '{2'd3, 32'h0000_8000, 20'h00010, 32'h0000_9001, 20'h00010, 32'h0000_A000, 20'h00010, 4'd0, 1'b1}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2 R6";
      1: return "R5";
      2: return "R5 R2";
      3: return "R3";
      4: return "R4";
      5: return "R4 R3";
      6: return "R5 R3";
      7: return "R5";
      8: return "R7 exact";
      9: return "R7";
      10: return "R8";
      11: return "R9 addr";
      12: return "R9 len";
      13: return "R5 below";
      14: return "R10 R7";
      default: return "R10 R9";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic seg_valid = 1'b0;
  logic seg_ready;
  logic [31:0] seg_addr = '0;
  logic [LEN_W-1:0] seg_len = '0;
  logic seg_last = 1'b0;
  logic desc_we;
  logic [AW-1:0] desc_waddr;
  logic [31:0] desc_wdata;
  logic done;
  logic [CW-1:0] entry_count;
  logic fail;

  always #4 clk = ~clk;

  sg_desc_builder #(.CAPACITY(CAP), .LEN_W(LEN_W), .SZ_W(SZ_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last),
    .desc_we(desc_we), .desc_waddr(desc_waddr), .desc_wdata(desc_wdata),
    .done(done), .entry_count(entry_count), .fail(fail)
  );

  int checks = 0;
  int errors = 0;
  int wr_total = 0;
  int mark_total = 0;
  logic [31:0] mem [0:2*CAP-1];

  always @(posedge clk) begin
    if (desc_we) begin
      mem[desc_waddr] <= desc_wdata;
      wr_total <= wr_total + 1;
      if (desc_wdata[31]) mark_total <= mark_total + 1;
    end
  end

  int          n_model;
  logic [31:0] exp_a [0:15];
  logic [16:0] exp_l [0:15];

  function automatic logic [31:0] seg_a(input vec_t v, input int i);
    case (i) 0: return v.a0; 1: return v.a1; default: return v.a2; endcase
  endfunction
  function automatic logic [LEN_W-1:0] seg_l(input vec_t v, input int i);
    case (i) 0: return v.l0; 1: return v.l1; default: return v.l2; endcase
  endfunction

  task automatic split_region(input logic [31:0] a, input longint s);
    longint edge_b, c;
    logic [31:0] pa;
    pa = a;
    while (s > 0) begin
      edge_b = 64'h10000 - longint'(pa[15:0]);
      c = (s < edge_b) ? s : edge_b;
      if (n_model < 16) begin
        exp_a[n_model] = pa;
        exp_l[n_model] = 17'(c);
      end
      n_model++;
      pa = pa + 32'(c);
      s  = s - c;
    end
  endtask

  task automatic build_model(input vec_t v);
    logic [31:0] pa;
    longint ps;
    bit have;
    n_model = 0;
    have = 0;
    pa = '0;
    ps = 0;
    for (int i = 0; i < int'(v.nseg); i++) begin
      if (have && (seg_a(v, i) == pa + 32'(ps))) begin
        ps = ps + longint'(seg_l(v, i));
      end else begin
        if (have) split_region(pa, ps);
        pa = seg_a(v, i);
        ps = longint'(seg_l(v, i));
        have = 1;
      end
    end
    if (have) split_region(pa, ps);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_case(input int idx);
    vec_t v;
    int w0, m0, guard;
    logic [31:0] exp_w;
    v = VECS[idx];
    build_model(v);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w0 = wr_total;
    m0 = mark_total;
    // R12: counters cleared by start
    check(entry_count == '0 && fail == 1'b0, "R12 clear", {31'(entry_count), fail}, 32'h0);
    for (int i = 0; i < int'(v.nseg); i++) begin
      seg_valid = 1'b1;
      seg_addr  = seg_a(v, i);
      seg_len   = seg_l(v, i);
      seg_last  = (i == int'(v.nseg) - 1);
      guard = 0;
      while (!seg_ready && guard < 2000) begin
        @(negedge clk);
        guard++;
      end
      check(guard < 2000, "R11 ready timeout", 32'(guard), 32'd0);
      @(negedge clk);
    end
    seg_valid = 1'b0;
    seg_last  = 1'b0;
    // R11: ready drops once the final segment is taken
    check(seg_ready == 1'b0, "R11 ready after last", 32'(seg_ready), 32'h0);
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, {tag_of(idx), " done"}, 32'(done), 32'h1);
    check(fail == v.exp_fail, {tag_of(idx), " fail"}, 32'(fail), 32'(v.exp_fail));
    check(entry_count == CW'(v.exp_cnt), {tag_of(idx), " count"}, 32'(entry_count), 32'(v.exp_cnt));
    if (!v.exp_fail) begin
      for (int k = 0; k < n_model && k < CAP; k++) begin
        check(mem[2*k] == exp_a[k], {tag_of(idx), " base R2"}, mem[2*k], exp_a[k]);
        exp_w = {(k == n_model - 1), 15'h0, exp_l[k][15:0]};
        check(mem[2*k+1] == exp_w, {tag_of(idx), " count word R2 R6"}, mem[2*k+1], exp_w);
      end
      check(wr_total - w0 == 2*n_model + 1, {tag_of(idx), " writes R6"}, 32'(wr_total - w0), 32'(2*n_model + 1));
      check(mark_total - m0 == 1, {tag_of(idx), " marks R6"}, 32'(mark_total - m0), 32'd1);
    end else begin
      check(mark_total - m0 == 0, {tag_of(idx), " no mark R7"}, 32'(mark_total - m0), 32'd0);
    end
    @(negedge clk);
    // R11: done lasts one cycle
    check(done == 1'b0 && seg_ready == 1'b0, "R11 done pulse", {30'h0, done, seg_ready}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w_idle;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    check(seg_ready == 0 && desc_we == 0 && done == 0 && fail == 0 && entry_count == 0,
          "R1 in reset", {27'h0, seg_ready, desc_we, done, fail, 1'b0}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(seg_ready == 0 && desc_we == 0 && done == 0 && fail == 0 && entry_count == 0,
          "R1 after reset", {27'h0, seg_ready, desc_we, done, fail, 1'b0}, 32'h0);
    // R11: an idle block offers no ready and writes nothing
    w_idle = wr_total;
    seg_valid = 1'b1;
    seg_addr  = 32'h0000_4000;
    seg_len   = 20'h00100;
    seg_last  = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(seg_ready == 1'b0 && done == 1'b0, "R11 idle ignore", {30'h0, seg_ready, done}, 32'h0);
    end
    check(wr_total == w_idle, "R11 idle no write", 32'(wr_total - w_idle), 32'h0);
    seg_valid = 1'b0;
    seg_last  = 1'b0;
    for (int i = 0; i < NV; i++) run_case(i);
    // R12: a good request after failures starts clean
    run_case(0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule